// File: doc/BRIEF.md
# Optical Insertion-Key Echo and Bypass Recognizer

This block sits behind the optical squelch of a ring media converter. It samples a qualified "light present" level once per slow reference tick and measures the length of each run of equal samples in ticks. It compares the run lengths against acceptance windows to spot the insertion key, or the echo of a key this side has sent. It also spots the bypass key, which is a long stretch with no light.

A run of "no light" is called dark and a run of "light present" is called lit. The insertion pattern has four elements in a fixed order. It starts with a short dark element, then a long lit element, then a second short dark element, and ends with a final lit element that is at least a minimum length. Recognition fires as soon as the final lit element reaches that minimum, without waiting for it to end.

The key generator sends an arm strobe when it starts sending its own key. If the timeout enable is high, the strobe starts an echo watch. The watch reports a late echo when no insertion pattern has been recognized within a fixed number of ticks. All timing constants are parameters. With a 30.5 µs tick the defaults are:

| Element | Window in ticks |
|---|---|
| short dark | 25 to 29 |
| long lit | 50 to 59 |
| final lit | at least 50 |
| bypass idle | 140 |
| echo timeout | 3277 |

Top module: `optkey_recognizer`

## Requirements
- R1: After a synchronous reset, `key_hit_o`, `bypass_hit_o` and `echo_late_o` are low, the matcher looks for a first element, and no echo watch is running.
- R2: A short dark element is accepted only when it lasts E1_LO..E1_HI ticks (default 25..29). A first element is also accepted only if it began with a change from lit to dark. The dark run that begins at reset never counts as a first element.
- R3: The long lit element (second element) is accepted only when it lasts E2_LO..E2_HI ticks (default 50..59).
- R4: The required order is short dark, long lit, short dark, final lit. `key_hit_o` fires on the tick where the final lit run reaches E3_LO samples (default 50). A final lit run shorter than that gives no hit.
- R5: Any element outside its window returns the matcher to looking for a first element. The next dark run can then begin a new key at once.
- R6: `bypass_hit_o` fires on the tick that brings a dark run to BYP_TICKS consecutive samples (default 140). It fires only once per dark run. Dark runs shorter than that give no bypass.
- R7: `arm_i` with `wait_en_i` high starts (or restarts) an echo watch. `echo_late_o` fires on the ECHO_TICKS-th tick after the arm cycle (default 3277), unless an insertion hit comes first. A hit ends the watch.
- R8: With `wait_en_i` low, `arm_i` is ignored, and dropping `wait_en_i` cancels a running watch.
- R9: Every output is a one-clock pulse. It is raised in the cycle after the clock edge that sampled the tick. `light_ok_i` has no effect in cycles where `tick_i` is low.
- R10: `key_hit_o` and `echo_late_o` are never high together. A hit on the same tick as the watch expiry suppresses the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle reference tick enable |
| light_ok_i | input | 1 | Qualified optical signal present (1 = lit) |
| arm_i | input | 1 | Key generation started; starts the echo watch |
| wait_en_i | input | 1 | Enables the echo watch |
| key_hit_o | output | 1 | Insertion pattern recognized (pulse) |
| bypass_hit_o | output | 1 | Bypass idle recognized (pulse) |
| echo_late_o | output | 1 | Echo watch expired (pulse) |

## Verification
Each result comes from exactly one register behind the tick edge. The bench raises `tick_i` at a falling edge and reads all three outputs at the next falling edge, where any pulse is due. It then reads them again one cycle later, where all must be low again. Echo-watch expiry is counted in ticks from the arm cycle, not in clocks, so the bench keeps `arm_i` and `wait_en_i` changes away from tick cycles. Directed runs sit on both edges of every window. Per-scenario pulse totals are checked against hand-derived counts.

// File: rtl/optkey_pkg.sv
package optkey_pkg;

    localparam int unsigned DEF_E1_LO    = 25;
    localparam int unsigned DEF_E1_HI    = 29;
    localparam int unsigned DEF_E2_LO    = 50;
    localparam int unsigned DEF_E2_HI    = 59;
    localparam int unsigned DEF_E3_LO    = 50;
    localparam int unsigned DEF_BYP      = 140;
    localparam int unsigned DEF_ECHO     = 3277;

    // matcher position: which element is expected next
    typedef enum logic [1:0] {
        MS_FIRST  = 2'd0,
        MS_SECOND = 2'd1,
        MS_THIRD  = 2'd2,
        MS_LAST   = 2'd3
    } match_stage_e;

    // what the current tick does to the run being measured
    typedef struct packed {
        logic ended;   // level changed: previous run is complete
        logic same;    // level unchanged: run grows by one
        logic lvl;     // level of the run before this tick
        logic whole;   // that run began with a level change
    } run_evt_t;

    function automatic logic win_hit(int unsigned v, int unsigned lo, int unsigned hi);
        return (v >= lo) && (v <= hi);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/optkey_run_tracker.sv
module optkey_run_tracker
    import optkey_pkg::*;
#(
    parameter int unsigned RUN_SAT = 141,
    parameter int unsigned RUN_W   = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             lvl_i,
    output run_evt_t         evt_o,
    output logic [RUN_W-1:0] run_len_o,
    output logic [RUN_W-1:0] run_nxt_o
);
    logic             lvl_q;
    logic             whole_q;
    logic [RUN_W-1:0] cnt_q;

    always_comb begin
        evt_o.ended = tick_i && (lvl_i != lvl_q);
        evt_o.same  = tick_i && (lvl_i == lvl_q);
        evt_o.lvl   = lvl_q;
        evt_o.whole = whole_q;
        run_len_o   = cnt_q;
        if (evt_o.ended)
            run_nxt_o = RUN_W'(1);
        else if (cnt_q == RUN_W'(RUN_SAT))
            run_nxt_o = cnt_q;
        else
            run_nxt_o = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lvl_q   <= 1'b0;
            whole_q <= 1'b0;
            cnt_q   <= '0;
        end else if (tick_i) begin
            cnt_q <= run_nxt_o;
            if (evt_o.ended) begin
                lvl_q   <= lvl_i;
                whole_q <= 1'b1;
            end
        end
    end

    // a tick with no level change never shortens the run
    assert_run_grows_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && (lvl_i == lvl_q)) |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/optkey_key_matcher.sv
module optkey_key_matcher
    import optkey_pkg::*;
#(
    parameter int unsigned E1_LO = 25,
    parameter int unsigned E1_HI = 29,
    parameter int unsigned E2_LO = 50,
    parameter int unsigned E2_HI = 59,
    parameter int unsigned E3_LO = 50,
    parameter int unsigned RUN_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  run_evt_t         evt_i,
    input  logic [RUN_W-1:0] run_len_i,
    input  logic [RUN_W-1:0] run_nxt_i,
    output logic             hit_now_o,
    output logic             hit_o
);
    match_stage_e stage_q, stage_d;
    logic         e1_ok, e2_ok;

    always_comb begin
        e1_ok     = win_hit(32'(run_len_i), E1_LO, E1_HI);
        e2_ok     = win_hit(32'(run_len_i), E2_LO, E2_HI);
        stage_d   = stage_q;
        hit_now_o = 1'b0;
        if (evt_i.ended) begin
            if (!evt_i.lvl) begin
                if (stage_q == MS_FIRST && evt_i.whole && e1_ok)
                    stage_d = MS_SECOND;
                else if (stage_q == MS_THIRD && e1_ok)
                    stage_d = MS_LAST;
                else
                    stage_d = MS_FIRST;
            end else begin
                stage_d = (stage_q == MS_SECOND && e2_ok) ? MS_THIRD : MS_FIRST;
            end
        end else if (evt_i.same && evt_i.lvl && stage_q == MS_LAST
                     && run_nxt_i == RUN_W'(E3_LO)) begin
            hit_now_o = 1'b1;
            stage_d   = MS_FIRST;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= MS_FIRST;
            hit_o   <= 1'b0;
        end else begin
            stage_q <= stage_d;
            hit_o   <= hit_now_o;
        end
    end

    assert_hit_single_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |=> !hit_o);

    assert_hit_on_lit_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |-> ($past(evt_i.same) && $past(evt_i.lvl)));

    assert_hit_restarts_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |-> (stage_q == MS_FIRST));

endmodule

// File: rtl/optkey_idle_detector.sv
module optkey_idle_detector #(
    parameter int unsigned BYP_TICKS = 140,
    parameter int unsigned RUN_W     = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             dark_step_i,
    input  logic [RUN_W-1:0] run_nxt_i,
    output logic             byp_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)
            byp_o <= 1'b0;
        else
            byp_o <= dark_step_i && (run_nxt_i == RUN_W'(BYP_TICKS));
    end

    assert_byp_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        byp_o |=> !byp_o);

endmodule

// File: rtl/optkey_echo_timer.sv
module optkey_echo_timer #(
    parameter int unsigned ECHO_TICKS = 3277,
    parameter int unsigned T_W        = 12
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic arm_i,
    input  logic en_i,
    input  logic hit_now_i,
    output logic late_o
);
    logic           watch_q;
    logic [T_W-1:0] tcnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            watch_q <= 1'b0;
            tcnt_q  <= '0;
            late_o  <= 1'b0;
        end else begin
            late_o <= 1'b0;
            if (!en_i) begin
                watch_q <= 1'b0;
            end else if (arm_i) begin
                watch_q <= 1'b1;
                tcnt_q  <= '0;
            end else if (tick_i && watch_q) begin
                if (hit_now_i) begin
                    watch_q <= 1'b0;
                end else if (tcnt_q == T_W'(ECHO_TICKS - 1)) begin
                    late_o  <= 1'b1;
                    watch_q <= 1'b0;
                end else begin
                    tcnt_q <= tcnt_q + 1'b1;
                end
            end
        end
    end

    assert_late_armed_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        late_o |-> ($past(watch_q) && $past(en_i) && $past(tick_i)));

    assert_late_single_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        late_o |=> !late_o);

endmodule

// File: rtl/optkey_recognizer.sv
module optkey_recognizer
    import optkey_pkg::*;
#(
    parameter int unsigned E1_LO      = DEF_E1_LO,
    parameter int unsigned E1_HI      = DEF_E1_HI,
    parameter int unsigned E2_LO      = DEF_E2_LO,
    parameter int unsigned E2_HI      = DEF_E2_HI,
    parameter int unsigned E3_LO      = DEF_E3_LO,
    parameter int unsigned BYP_TICKS  = DEF_BYP,
    parameter int unsigned ECHO_TICKS = DEF_ECHO
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic light_ok_i,
    input  logic arm_i,
    input  logic wait_en_i,
    output logic key_hit_o,
    output logic bypass_hit_o,
    output logic echo_late_o
);
    localparam int unsigned RUN_SAT = max3(BYP_TICKS, E2_HI, E3_LO) + 1;
    localparam int unsigned RUN_W   = $clog2(RUN_SAT + 1);
    localparam int unsigned T_W     = $clog2(ECHO_TICKS + 1);

    run_evt_t         evt;
    logic [RUN_W-1:0] run_len;
    logic [RUN_W-1:0] run_nxt;
    logic             hit_now;

    optkey_run_tracker #(.RUN_SAT(RUN_SAT), .RUN_W(RUN_W)) u_track (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick_i),
        .lvl_i     (light_ok_i),
        .evt_o     (evt),
        .run_len_o (run_len),
        .run_nxt_o (run_nxt)
    );

    optkey_key_matcher #(
        .E1_LO(E1_LO), .E1_HI(E1_HI), .E2_LO(E2_LO), .E2_HI(E2_HI),
        .E3_LO(E3_LO), .RUN_W(RUN_W)
    ) u_match (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .evt_i     (evt),
        .run_len_i (run_len),
        .run_nxt_i (run_nxt),
        .hit_now_o (hit_now),
        .hit_o     (key_hit_o)
    );

    optkey_idle_detector #(.BYP_TICKS(BYP_TICKS), .RUN_W(RUN_W)) u_idle (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .dark_step_i (evt.same && !evt.lvl),
        .run_nxt_i   (run_nxt),
        .byp_o       (bypass_hit_o)
    );

    optkey_echo_timer #(.ECHO_TICKS(ECHO_TICKS), .T_W(T_W)) u_echo (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick_i),
        .arm_i     (arm_i),
        .en_i      (wait_en_i),
        .hit_now_i (hit_now),
        .late_o    (echo_late_o)
    );

    assert_no_clash_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !(key_hit_o && echo_late_o));

    assert_quiet_without_tick_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(tick_i) |-> !(key_hit_o || bypass_hit_o || echo_late_o));

endmodule

// File: tb/optkey_recognizer_tb.sv
`timescale 1ns/1ps
module optkey_recognizer_tb;
    localparam int L1 = 25, H1 = 29, L2 = 50, H2 = 59, L3 = 50;
    localparam int BYP = 140, ECHO = 3277;

    logic clk = 1'b0;
    logic rst_i = 1'b1, tick_i = 1'b0, light_ok_i = 1'b0, arm_i = 1'b0, wait_en_i = 1'b1;
    logic key_hit_o, bypass_hit_o, echo_late_o;

    always #2.5 clk = ~clk;

    optkey_recognizer u_dut (
        .clk_i(clk), .rst_i(rst_i), .tick_i(tick_i), .light_ok_i(light_ok_i),
        .arm_i(arm_i), .wait_en_i(wait_en_i), .key_hit_o(key_hit_o),
        .bypass_hit_o(bypass_hit_o), .echo_late_o(echo_late_o)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    // bench expectation state
    int m_lvl, m_cnt, m_whole, m_st, m_watch, m_tcnt;
    bit e_hit, e_byp, e_late;
    int o_hit, o_byp, o_late, s_hit, s_byp, s_late;

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit inw(int v, int lo, int hi);
        return v >= lo && v <= hi;
    endfunction

    function automatic void model_reset();
        m_lvl = 0; m_cnt = 0; m_whole = 0; m_st = 0; m_watch = 0; m_tcnt = 0;
    endfunction

    function automatic void model_tick(int v);
        e_hit = 0; e_byp = 0; e_late = 0;
        if (v == m_lvl) begin
            m_cnt++;
            if (v == 0 && m_cnt == BYP) e_byp = 1;
            if (v == 1 && m_st == 3 && m_cnt == L3) begin e_hit = 1; m_st = 0; end
        end else begin
            if (m_lvl == 0)
                m_st = (m_st == 0 && m_whole == 1 && inw(m_cnt, L1, H1)) ? 1 :
                       (m_st == 2 && inw(m_cnt, L1, H1)) ? 3 : 0;
            else
                m_st = (m_st == 1 && inw(m_cnt, L2, H2)) ? 2 : 0;
            m_lvl = v; m_cnt = 1; m_whole = 1;
        end
        if (m_watch == 1) begin
            if (e_hit) m_watch = 0;
            else begin
                m_tcnt++;
                if (m_tcnt == ECHO) begin e_late = 1; m_watch = 0; end
            end
        end
    endfunction

    task automatic tick_once(int v);
        @(negedge clk); tick_i = 1'b1; light_ok_i = v[0];
        @(negedge clk); tick_i = 1'b0;
        model_tick(v);
        o_hit += int'(key_hit_o); o_byp += int'(bypass_hit_o); o_late += int'(echo_late_o);
        chk("R4", "key_hit", int'(key_hit_o), int'(e_hit));
        chk("R6", "bypass_hit", int'(bypass_hit_o), int'(e_byp));
        chk("R7", "echo_late", int'(echo_late_o), int'(e_late));
        @(negedge clk);
        chk("R9", "pulse width", int'(key_hit_o | bypass_hit_o | echo_late_o), 0);
    endtask

    task automatic run(int v, int n);
        for (int i = 0; i < n; i++) tick_once(v);
    endtask

    task automatic key(int a, int b, int c, int d);
        run(0, a); run(1, b); run(0, c); run(1, d);
    endtask

    task automatic arm();
        @(negedge clk); arm_i = 1'b1;
        @(negedge clk); arm_i = 1'b0;
        if (wait_en_i) begin m_watch = 1; m_tcnt = 0; end
    endtask

    task automatic set_en(bit en);
        @(negedge clk); wait_en_i = en;
        if (!en) m_watch = 0;
        @(negedge clk);
    endtask

    task automatic glitch();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); light_ok_i = ~light_ok_i;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_i = 1'b1; tick_i = 1'b0; arm_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_i = 1'b0; model_reset();
    endtask

    task automatic snap();
        s_hit = o_hit; s_byp = o_byp; s_late = o_late;
    endtask

    task automatic expect_delta(string req, int dh, int db, int dl);
        chk(req, "hit total", o_hit - s_hit, dh);
        chk(req, "bypass total", o_byp - s_byp, db);
        chk(req, "late total", o_late - s_late, dl);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_up();
    end

    initial begin
        o_hit = 0; o_byp = 0; o_late = 0;
        model_reset();
        do_reset();
        @(negedge clk);
        chk("R1", "outputs after reset", int'({key_hit_o, bypass_hit_o, echo_late_o}), 0);

        // R2: dark run that starts at reset is not a first element
        snap(); run(0, 27); run(1, 55); run(0, 27); run(1, 60);
        expect_delta("R2", 0, 0, 0);
        // R4: nominal key
        snap(); key(27, 55, 27, 60); expect_delta("R4", 1, 0, 0);
        // R2/R3: window edges accepted
        snap(); key(L1, L2, L1, L3); key(H1, H2, H1, 80); expect_delta("R3", 2, 0, 0);
        // R2/R3/R4: just outside each window
        snap();
        key(L1 - 1, 55, 27, 60); key(H1 + 1, 55, 27, 60);
        key(27, L2 - 1, 27, 60); key(27, H2 + 1, 27, 60); key(27, 55, 27, L3 - 1);
        expect_delta("R2", 0, 0, 0);
        // R5: bad element then a fresh key right away
        snap(); run(0, 27); run(1, 40); key(27, 55, 27, 60); expect_delta("R5", 1, 0, 0);
        // R6: bypass threshold
        snap(); run(0, BYP - 1); run(1, 5); run(0, 200); run(1, 5);
        expect_delta("R6", 0, 1, 0);
        // R9: light changes between ticks have no effect
        snap();
        run(0, 27); glitch(); run(1, 55); glitch(); run(0, 27); glitch(); run(1, 60);
        expect_delta("R9", 1, 0, 0);
        // R7: plain timeout
        snap(); arm(); run(1, ECHO); expect_delta("R7", 0, 0, 1);
        // R7: re-arm restarts the watch
        snap(); arm(); run(1, 2000); arm(); run(1, 2000); expect_delta("R7", 0, 0, 0);
        run(1, ECHO - 2000); expect_delta("R7", 0, 0, 1);
        // R7: hit ends the watch
        snap(); arm(); key(27, 55, 27, 60); run(1, ECHO); expect_delta("R7", 1, 0, 0);
        // R8: disabled watch
        snap(); set_en(0); arm(); run(1, ECHO + 20); expect_delta("R8", 0, 0, 0);
        set_en(1); arm(); run(1, 1000); set_en(0); set_en(1); run(1, ECHO);
        expect_delta("R8", 0, 0, 0);
        // R10: hit lands on the expiry tick
        snap(); arm(); run(1, ECHO - (27 + 55 + 27 + L3)); key(27, 55, 27, L3);
        expect_delta("R10", 1, 0, 0);
        run(1, 10);

        // random runs mixed with keys and arms
        void'($urandom(32'h0DD5EED));
        for (int r = 0; r < 60; r++) begin
            int sel, len;
            sel = int'($urandom_range(0, 9));
            if (sel == 0) begin
                arm();
            end else if (sel < 3) begin
                key(int'($urandom_range(23, 31)), int'($urandom_range(48, 61)),
                    int'($urandom_range(23, 31)), int'($urandom_range(45, 70)));
            end else begin
                len = (sel < 6) ? int'($urandom_range(1, 35)) :
                      (sel < 9) ? int'($urandom_range(40, 70)) :
                                  int'($urandom_range(130, 150));
                run((m_lvl == 0) ? 1 : 0, len);
            end
        end

        finish_up();
    end
endmodule